// File: doc/BRIEF.md
# Latched One-of-Sixteen Address Decoder

This block turns a 4-bit address into a 16-line select vector in which exactly one line is active. The address passes through a capture stage controlled by a strobe input. While strobe is high the stage is transparent: the outputs track the address inputs within the same cycle. When strobe drops, the stage keeps the address it sampled at the last rising clock edge on which strobe was still high. The outputs then stay fixed, whatever the address pins do, until strobe rises again.

An inhibit input drives every output line to its inactive level without delay. The captured address is not touched, so the old selection comes back as soon as inhibit is released. The build parameter `ACTIVE_LOW` sets the output polarity. At 0 the selected line is 1 and all other lines are 0. At 1 the selected line is 0 and all other lines are 1. Both polarities share the same decode logic. A typical use is to steer a single serial bit to one of sixteen destination registers, with inhibit carrying the data.

Top module: `latched_decoder`

## Requirements
- R1: While `strobe` is 1 and `inhibit` is 0, `sel_out` reflects the present `data_in` in the same cycle, with no clock edge in between.
- R2: While `strobe` is 0, changes on `data_in` have no effect on `sel_out`. The output shows the address captured at the last rising `clk` edge on which `strobe` was 1.
- R3: While `inhibit` is 1, every bit of `sel_out` takes its inactive value: all 0 when `ACTIVE_LOW`=0 and all 1 when `ACTIVE_LOW`=1. This happens in the same cycle, with no clock edge needed.
- R4: `data_in[0]` is the least significant address bit and `data_in[3]` the most significant. The binary value k selects bit k of `sel_out`.
- R5: With `ACTIVE_LOW`=0 and `inhibit` at 0, bit k of `sel_out` is 1 and all 15 other bits are 0.
- R6: With `ACTIVE_LOW`=1 and `inhibit` at 0, bit k of `sel_out` is 0 and all 15 other bits are 1.
- R7: Asserting `inhibit` does not change the captured address. After `inhibit` returns to 0 with `strobe` at 0, the address captured before is shown again.
- R8: An active-low `rst_n` clears the captured address to 0 asynchronously. With `strobe` at 0 and `inhibit` at 0, only line 0 is then active.
- R9: The capture register samples `data_in` on the rising `clk` edge. If `strobe` falls and `data_in` changes in the same cycle, the value from the last edge on which `strobe` was high is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address capture register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the captured address |
| strobe | input | 1 | 1: capture stage transparent; 0: hold the captured address |
| inhibit | input | 1 | 1: force all outputs to the inactive level |
| data_in | input | 4 | Address, bit 0 least significant |
| sel_out | output | 16 | Select vector, one line active at the chosen polarity |

## Verification
Two instances run in parallel, one with active-high outputs and one with active-low outputs, and every check compares both. A full sweep of the sixteen addresses under strobe separates a correct bit weighting from swapped or stuck address lines. It also separates a true one-hot or one-cold result from a vector with extra or missing active bits. Address changes made while strobe is low tell a holding stage apart from one that stays transparent. A strobe fall made together with a data change shows whether the kept value comes from the last sampling edge. Inhibit pulses, both with strobe high and with strobe low, followed by a release, show that the override acts at the output only. A reset given in the middle of the run confirms that the captured address returns to zero.

// File: rtl/latdec_pkg.sv
package latdec_pkg;

  localparam int unsigned ADDR_W_MAX = 6;

  // Reference one-hot value for address idx; callers truncate to their width.
  function automatic logic [63:0] onehot64(input int unsigned idx);
    return 64'(1) << idx;
  endfunction

endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] addr_eff
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (strobe) held_q <= data_in;
  end

  // transparent path while strobe is high, captured value otherwise
  assign addr_eff = strobe ? data_in : held_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> held_q == $past(held_q));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> held_q == $past(data_in));

endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
  parameter int unsigned W = 4,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] addr,
  output logic [N-1:0] dec
);

  for (genvar k = 0; k < N; k++) begin : g_line
    assign dec[k] = (addr == W'(k));
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned N          = 16,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic [N-1:0] dec,
  input  logic         inhibit,
  output logic [N-1:0] sel_out
);

  localparam logic [N-1:0] POL_MASK = {N{ACTIVE_LOW}};

  logic [N-1:0] gated;

  assign gated   = inhibit ? '0 : dec;
  assign sel_out = gated ^ POL_MASK;

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned ADDR_W     = 4,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe,
  input  logic                     inhibit,
  input  logic [ADDR_W-1:0]        data_in,
  output logic [(1<<ADDR_W)-1:0]   sel_out
);

  localparam int unsigned OUT_N = 1 << ADDR_W;

  initial begin
    if (ADDR_W > latdec_pkg::ADDR_W_MAX || ADDR_W == 0)
      $error("latched_decoder: ADDR_W out of range");
  end

  logic [ADDR_W-1:0] addr_eff;
  logic [OUT_N-1:0]  dec_vec;

  addr_latch #(.W(ADDR_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .data_in  (data_in),
    .addr_eff (addr_eff)
  );

  onehot_decoder #(.W(ADDR_W)) u_dec (
    .addr (addr_eff),
    .dec  (dec_vec)
  );

  out_stage #(.N(OUT_N), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .dec     (dec_vec),
    .inhibit (inhibit),
    .sel_out (sel_out)
  );

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_vec) == 1);

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> sel_out == {OUT_N{ACTIVE_LOW}});

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !inhibit) |->
      sel_out == (OUT_N'(latdec_pkg::onehot64(int'(data_in))) ^ {OUT_N{ACTIVE_LOW}}));

  assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |-> $countones(sel_out) == (ACTIVE_LOW ? OUT_N - 1 : 1));

endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic        inhibit;
  logic [3:0]  data_in;
  logic [15:0] hi_out;
  logic [15:0] lo_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  latched_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inhibit(inhibit),
    .data_in(data_in), .sel_out(hi_out)
  );

  latched_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b1)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inhibit(inhibit),
    .data_in(data_in), .sel_out(lo_out)
  );

  // {strobe, inhibit, data[3:0], expected addr[3:0], expected inactive}
  localparam logic [10:0] VEC [12] = '{
    {1'b1, 1'b0, 4'h5, 4'h5, 1'b0},   // R1 transparent
    {1'b0, 1'b0, 4'h9, 4'h5, 1'b0},   // R2 hold
    {1'b0, 1'b0, 4'hF, 4'h5, 1'b0},   // R2 hold
    {1'b1, 1'b0, 4'hA, 4'hA, 1'b0},   // R1
    {1'b1, 1'b1, 4'h3, 4'h3, 1'b1},   // R3 inhibit while transparent
    {1'b0, 1'b1, 4'h7, 4'h3, 1'b1},   // R3 inhibit while holding
    {1'b0, 1'b0, 4'h7, 4'h3, 1'b0},   // R7 captured value back
    {1'b1, 1'b0, 4'hF, 4'hF, 1'b0},   // R1
    {1'b0, 1'b0, 4'h0, 4'hF, 1'b0},   // R2
    {1'b1, 1'b0, 4'h0, 4'h0, 1'b0},   // R1
    {1'b0, 1'b0, 4'h8, 4'h0, 1'b0},   // R2
    {1'b1, 1'b1, 4'hC, 4'hC, 1'b1}    // R3
  };

  function automatic logic [15:0] model_hi(input logic [3:0] a, input bit inact);
    logic [15:0] v;
    for (int k = 0; k < 16; k++) v[k] = !inact && (k == int'(a));
    return v;
  endfunction

  task automatic check_pair(input string req, input logic [3:0] a, input bit inact);
    logic [15:0] exp_hi;
    logic [15:0] exp_lo;
    exp_hi = model_hi(a, inact);
    exp_lo = ~exp_hi;
    n_checks++;
    if (hi_out !== exp_hi || lo_out !== exp_lo) begin
      n_fail++;
      $display("FAIL %s: high=%h low=%h expected high=%h low=%h",
               req, hi_out, lo_out, exp_hi, exp_lo);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    strobe  = 1'b0;
    inhibit = 1'b0;
    data_in = 4'hB;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check_pair("R8 reset", 4'h0, 1'b0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      strobe  = VEC[i][10];
      inhibit = VEC[i][9];
      data_in = VEC[i][8:5];
      #1 check_pair($sformatf("R1/R2/R3/R7 vector %0d", i), VEC[i][4:1], VEC[i][0]);
    end

    // full address sweep, both polarities
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      strobe  = 1'b1;
      inhibit = 1'b0;
      data_in = 4'(a);
      #1 check_pair($sformatf("R4 R5 R6 address %0d", a), 4'(a), 1'b0);
    end

    // strobe fall with simultaneous data change
    @(negedge clk);
    strobe  = 1'b1;
    data_in = 4'h6;
    @(negedge clk);
    strobe  = 1'b0;
    data_in = 4'h2;
    #1 check_pair("R9 edge capture", 4'h6, 1'b0);

    // inhibit without a clock edge, then release
    @(negedge clk);
    #1 inhibit = 1'b1;
    #0.5 check_pair("R3 immediate inhibit", 4'h6, 1'b1);
    data_in = 4'h1;
    @(negedge clk);
    inhibit = 1'b0;
    #1 check_pair("R7 release", 4'h6, 1'b0);

    // asynchronous reset mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check_pair("R8 async reset", 4'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_pair("R8 after reset", 4'h0, 1'b0);

    finish_run();
  end

endmodule